// File: doc/BRIEF.md
# Reset Vector Fetch Sequencer

This block sits between a core's reset control and its instruction fetch unit. After reset is released it reads two words from a vector table over a request/acknowledge memory read port. The first word becomes the initial main stack pointer. The second word is the address of the reset handler. After both reads have completed, it hands a branch target to the fetch unit and allows fetch to start.

The table base comes from a vector table base register input. The low bits of that register are ignored, so the table always starts on an aligned boundary. The block also gives preset values for the link register and the process stack pointer. A reset at any point aborts the sequence. A new sequence starts once reset is released again.

Top module: `rst_vec_seq`

## Requirements
- R1: The first read goes to `vtbl_base` with bits 6:0 forced to zero, which is the table base. The base is taken when the sequence leaves its reset state.
- R2: `msp_load` is a single-cycle pulse in the cycle after the first read is acknowledged. During that pulse `msp_value` equals the first word with bits 1:0 cleared.
- R3: `lr_load` pulses in the same cycle as `msp_load`, with `lr_value` equal to 0xFFFFFFFF.
- R4: `psp_value` is zero whenever `msp_load` is high. This gives a process stack pointer with bits 1:0 clear and its upper bits driven to zero.
- R5: The second read goes to table base + 4. It is issued only after the first read has been acknowledged, so exactly two reads occur per sequence.
- R6: While `rd_req` is high and `rd_ack` is low, `rd_req` and `rd_addr` hold their values into the next cycle. An acknowledge may arrive after one or more cycles.
- R7: `start_valid` is a single-cycle pulse that occurs only after both reads have completed. During that pulse `start_addr` equals the second word with bit 0 cleared.
- R8: `fetch_en` is low from reset until the `start_valid` cycle. It is high in that cycle and stays high until the next reset. `fetch_en` is never high while a read is requested.
- R9: Asserting `rst_n` low at any time immediately drops `fetch_en`, `rd_req`, `start_valid` and the load strobes. On the first clock edge after release, `rd_req` rises and a new sequence begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vtbl_base | input | XLEN | Vector table base register |
| rd_req | output | 1 | Memory read request |
| rd_addr | output | XLEN | Memory read byte address |
| rd_ack | input | 1 | Read acknowledge, with data valid |
| rd_data | input | XLEN | Read data |
| msp_load | output | 1 | Main stack pointer load strobe |
| msp_value | output | XLEN | Main stack pointer value |
| psp_value | output | XLEN | Process stack pointer value, loaded with `msp_load` |
| lr_load | output | 1 | Link register load strobe |
| lr_value | output | XLEN | Link register preset value |
| fetch_en | output | 1 | Instruction fetch enable |
| start_valid | output | 1 | Start address valid pulse |
| start_addr | output | XLEN | Reset handler branch target |

## Verification
The bench builds the block with its default parameters: XLEN of 32, a table alignment of 7 bits, and an all-ones link register preset. These are the values the requirements state. With these values, the bench can run a base register that has every low bit set, and a base near the top of the address space. It also checks handler words whose bit 0 is set or clear, and stack words with dirty low bits. The bench's memory responder changes the acknowledge latency between runs. This covers both a read completed on its first request cycle and a read that waits for several cycles. A reset asserted in the middle of a read checks the abort path.

// File: rtl/rst_vec_seq.sv
module rst_vec_seq #(
  parameter int XLEN = 32,
  parameter int TBL_ALIGN = 7,
  parameter logic [XLEN-1:0] LR_PRESET = '1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [XLEN-1:0] vtbl_base,
  output logic            rd_req,
  output logic [XLEN-1:0] rd_addr,
  input  logic            rd_ack,
  input  logic [XLEN-1:0] rd_data,
  output logic            msp_load,
  output logic [XLEN-1:0] msp_value,
  output logic [XLEN-1:0] psp_value,
  output logic            lr_load,
  output logic [XLEN-1:0] lr_value,
  output logic            fetch_en,
  output logic            start_valid,
  output logic [XLEN-1:0] start_addr
);
  localparam logic [XLEN-1:0] TBL_MASK  = ~((XLEN'(1) << TBL_ALIGN) - XLEN'(1));
  localparam logic [XLEN-1:0] SP_MASK   = ~XLEN'(3);
  localparam logic [XLEN-1:0] PC_MASK   = ~XLEN'(1);
  localparam logic [XLEN-1:0] WORD_STEP = XLEN'(XLEN / 8);

  typedef enum logic [2:0] {
    S_RESET, S_READ_SP, S_WAIT_SP, S_READ_PC, S_WAIT_PC, S_BRANCH, S_RUN
  } seq_t;

  seq_t st, st_nx;
  logic [XLEN-1:0] base_q, sp_q, pc_q;
  logic sp_pulse;

  wire in_sp = (st == S_READ_SP) || (st == S_WAIT_SP);
  wire in_pc = (st == S_READ_PC) || (st == S_WAIT_PC);

  always_comb begin
    st_nx = st;
    case (st)
      S_RESET:   st_nx = S_READ_SP;
      S_READ_SP: st_nx = rd_ack ? S_READ_PC : S_WAIT_SP;
      S_WAIT_SP: if (rd_ack) st_nx = S_READ_PC;
      S_READ_PC: st_nx = rd_ack ? S_BRANCH : S_WAIT_PC;
      S_WAIT_PC: if (rd_ack) st_nx = S_BRANCH;
      S_BRANCH:  st_nx = S_RUN;
      S_RUN:     st_nx = S_RUN;
      default:   st_nx = S_RESET;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_RESET;
      base_q   <= '0;
      sp_q     <= '0;
      pc_q     <= '0;
      sp_pulse <= 1'b0;
    end else begin
      st       <= st_nx;
      sp_pulse <= in_sp && rd_ack;
      if (st == S_RESET) base_q <= vtbl_base & TBL_MASK;
      if (in_sp && rd_ack) sp_q <= rd_data & SP_MASK;
      if (in_pc && rd_ack) pc_q <= rd_data & PC_MASK;
    end
  end

  assign rd_req      = in_sp || in_pc;
  assign rd_addr     = in_pc ? base_q + WORD_STEP : base_q;
  assign msp_load    = sp_pulse;
  assign lr_load     = sp_pulse;
  assign msp_value   = sp_q;
  assign psp_value   = '0;
  assign lr_value    = LR_PRESET;
  assign start_valid = (st == S_BRANCH);
  assign start_addr  = pc_q;
  assign fetch_en    = (st == S_BRANCH) || (st == S_RUN);
endmodule

// File: rtl/rst_vec_seq_chk.sv
module rst_vec_seq_chk #(
  parameter int XLEN = 32,
  parameter int TBL_ALIGN = 7
) (
  input logic            clk,
  input logic            rst_n,
  input logic            rd_req,
  input logic [XLEN-1:0] rd_addr,
  input logic            rd_ack,
  input logic            msp_load,
  input logic [XLEN-1:0] msp_value,
  input logic [XLEN-1:0] psp_value,
  input logic            lr_load,
  input logic            fetch_en,
  input logic            start_valid,
  input logic [XLEN-1:0] start_addr
);
  p_addr_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_addr[TBL_ALIGN-1:0] == '0) || (rd_addr[TBL_ALIGN-1:0] == TBL_ALIGN'(XLEN / 8)));

  p_sp_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    msp_load |=> !msp_load);

  p_sp_align_r2: assert property (@(posedge clk) disable iff (!rst_n)
    msp_load |-> msp_value[1:0] == 2'b00);

  p_lr_with_sp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lr_load |-> msp_load);

  p_psp_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    msp_load |-> psp_value == '0);

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> rd_req && $stable(rd_addr));

  p_start_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid |=> !start_valid);

  p_start_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid |-> !start_addr[0] && fetch_en);

  p_fetch_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_en |=> fetch_en);

  p_no_fetch_in_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> !fetch_en);
endmodule

bind rst_vec_seq rst_vec_seq_chk #(.XLEN(XLEN), .TBL_ALIGN(TBL_ALIGN)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack),
  .msp_load(msp_load), .msp_value(msp_value), .psp_value(psp_value),
  .lr_load(lr_load), .fetch_en(fetch_en), .start_valid(start_valid),
  .start_addr(start_addr)
);

// File: tb/sim_rst_vec_seq.sv
module sim_rst_vec_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [31:0] vtbl_base = '0;
  logic rd_ack = 1'b0;
  logic [31:0] rd_data = '0;
  logic rd_req, msp_load, lr_load, fetch_en, start_valid;
  logic [31:0] rd_addr, msp_value, psp_value, lr_value, start_addr;

  int checks = 0;
  int errors = 0;
  int lat = 1;
  bit block_ack = 1'b0;
  int wait_cnt = 0;
  logic [31:0] mem_sp, mem_pc;

  always #10 clk = ~clk;

  rst_vec_seq u0 (
    .clk(clk), .rst_n(rst_n), .vtbl_base(vtbl_base),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
    .msp_load(msp_load), .msp_value(msp_value), .psp_value(psp_value),
    .lr_load(lr_load), .lr_value(lr_value), .fetch_en(fetch_en),
    .start_valid(start_valid), .start_addr(start_addr)
  );

  always @(negedge clk) begin
    if (!rst_n || rd_ack) begin
      rd_ack = 1'b0;
      wait_cnt = 0;
      rd_data = 32'h5A5A_5A5A;
    end else if (rd_req && !block_ack) begin
      wait_cnt++;
      if (wait_cnt >= lat) begin
        rd_ack = 1'b1;
        rd_data = (rd_addr == (vtbl_base & 32'hFFFF_FF80)) ? mem_sp :
                  (rd_addr == (vtbl_base & 32'hFFFF_FF80) + 32'd4) ? mem_pc : 32'hBAD0_BAD0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic boot(input logic [31:0] base, input logic [31:0] spw, input logic [31:0] pcw, input int l);
    int n_rd = 0, n_sp = 0, n_st = 0;
    logic [31:0] a0 = '0, a1 = '0, cap_sp = '0, cap_psp = '1, cap_lr = '0, cap_st = '0;
    bit lr_sync = 1'b1, fe_bad = 1'b0, hold_bad = 1'b0, started = 1'b0, st_early = 1'b0;
    bit prev_wait = 1'b0;
    logic [31:0] prev_addr = '0;
    @(negedge clk);
    rst_n = 1'b0;
    vtbl_base = base; mem_sp = spw; mem_pc = pcw; lat = l; block_ack = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk); #5;
      if (prev_wait && !(rd_req && rd_addr == prev_addr)) hold_bad = 1'b1;
      prev_wait = rd_req && !rd_ack;
      prev_addr = rd_addr;
      if (lr_load != msp_load) lr_sync = 1'b0;
      if (msp_load) begin n_sp++; cap_sp = msp_value; cap_psp = psp_value; cap_lr = lr_value; end
      if (start_valid) begin
        n_st++; cap_st = start_addr; started = 1'b1;
        if (n_rd != 2) st_early = 1'b1;
      end
      if (started != fetch_en) fe_bad = 1'b1;
      if (rd_req && rd_ack) begin
        if (n_rd == 0) a0 = rd_addr; else a1 = rd_addr;
        n_rd++;
      end
    end
    chk(a0 == (base & 32'hFFFF_FF80), "R1", a0, base & 32'hFFFF_FF80);
    chk(n_sp == 1 && cap_sp == (spw & 32'hFFFF_FFFC), "R2", cap_sp, spw & 32'hFFFF_FFFC);
    chk(lr_sync && cap_lr == 32'hFFFF_FFFF, "R3", cap_lr, 32'hFFFF_FFFF);
    chk(cap_psp == 32'h0, "R4", cap_psp, 32'h0);
    chk(n_rd == 2 && a1 == (base & 32'hFFFF_FF80) + 32'd4, "R5", a1, (base & 32'hFFFF_FF80) + 32'd4);
    chk(!hold_bad, "R6", {31'd0, hold_bad}, 32'd0);
    chk(n_st == 1 && !st_early && cap_st == (pcw & 32'hFFFF_FFFE), "R7", cap_st, pcw & 32'hFFFF_FFFE);
    chk(!fe_bad && fetch_en, "R8", {31'd0, fe_bad}, 32'd0);
  endtask

  task automatic reset_abort();
    @(negedge clk);
    rst_n = 1'b0;
    vtbl_base = 32'h0000_4000; mem_sp = 32'h2000_1000; mem_pc = 32'h0000_0201;
    block_ack = 1'b1; lat = 1;
    #5;
    chk(!rd_req && !fetch_en && !start_valid && !msp_load, "R9 reset state",
        {28'd0, rd_req, fetch_en, start_valid, msp_load}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #5;
    chk(rd_req && rd_addr == 32'h0000_4000, "R9 first clock", rd_addr, 32'h0000_4000);
    repeat (3) @(negedge clk);
    #5;
    rst_n = 1'b0;
    #1;
    chk(!rd_req && !fetch_en && !msp_load, "R9 abort mid read", {29'd0, rd_req, fetch_en, msp_load}, 32'd0);
    block_ack = 1'b0;
    boot(32'h0000_4000, 32'h2000_1000, 32'h0000_0201, 2);
    #5;
    rst_n = 1'b0;
    #1;
    chk(!fetch_en && !start_valid, "R9 abort after run", {30'd0, fetch_en, start_valid}, 32'd0);
  endtask

  initial begin
    fork
      begin
        boot(32'h0000_12FF, 32'h2000_7FFF, 32'h0800_0101, 1);
        boot(32'hFFFF_FF80, 32'h1234_5678, 32'hFFFF_FFFF, 4);
        boot(32'h0000_0000, 32'h2000_0003, 32'h0000_0400, 2);
        reset_abort();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule